// File: doc/BRIEF.md
# Phase Accumulator Modulation Front End

This block is the input stage of a numerically controlled waveform synthesizer. A single 32-bit phase port feeds two holding registers: a modulation word and a carrier word. A 2-bit load selector chooses which register captures the port on each clock. A 2-bit mode selector then decides how the two words form the phase that goes downstream. The words can be summed directly. The accumulator can advance by carrier plus modulation, which gives frequency modulation. The accumulator can advance by the carrier alone and have the modulation word added after it, which gives phase modulation. Both paths can also be enabled together.

A 15-bit amplitude register with its own load enable runs alongside the phase path. The phase and amplitude reach the outputs through the same number of registers, so a coordinate rotator placed after this block receives matched pairs. The phase word is a fraction of one full turn: its top bit weighs ±π and each lower bit weighs half the bit above it. All sums wrap modulo 2^32.

Top module: `phase_mod_front`

## Requirements
- R1: With load_sel = 2'b01 the modulation register captures phase_in and the carrier register keeps its value. With load_sel = 2'b10 the carrier register captures phase_in and the modulation register keeps its value.
- R2: With load_sel = 2'b00 both registers keep their values, whatever phase_in carries.
- R3: With load_sel = 2'b11 the modulation register is cleared to zero and the carrier register captures phase_in.
- R4: With mode_sel = 2'b00 the output phase is carrier + modulation, and the accumulator is held at zero.
- R5: With mode_sel = 2'b10 (frequency path, bit 1) the accumulator adds carrier + modulation on every clock, and the output phase is the updated accumulator value.
- R6: With mode_sel = 2'b01 (phase path, bit 0) the accumulator adds the carrier on every clock, and the output phase is the updated accumulator value plus the modulation word.
- R7: With mode_sel = 2'b11 both paths apply together: the accumulator adds carrier + modulation, and the modulation word is added again after the accumulator.
- R8: Every sum is taken modulo 2^32. Overflow wraps without any other effect.
- R9: The amplitude register captures amp_in on a clock edge only while amp_en is high, and keeps its value otherwise.
- R10: Inputs sampled at clock edge k affect phase_out and amp_out from edge k+1 onward. That is two register stages, and they are the same for both outputs.
- R11: A synchronous active-high rst clears both phase registers, the accumulator, the amplitude register and both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| phase_in | input | 32 | Phase word input, fraction of a turn |
| load_sel | input | 2 | Register load code (hold / modulation / carrier / clear-modulation-and-load-carrier) |
| mode_sel | input | 2 | Accumulation mode; bit 1 frequency path, bit 0 phase path |
| amp_in | input | 15 | Amplitude word input |
| amp_en | input | 1 | Amplitude register load enable |
| phase_out | output | 32 | Phase to the coordinate rotator |
| amp_out | output | 15 | Amplitude to the coordinate rotator, aligned with phase_out |

## Verification
The hardest condition to reach is the accumulator crossing 2^32 while both paths are active. In that case the post-accumulator modulation add also overflows. To get there, the stimulus first loads large carrier and modulation words using the load codes alone, with accumulation off. It then switches modes and runs for several clocks, so the accumulator passes through full turns. The bench also switches mode back to 2'b00 in the middle of a run, to show the accumulator restarting from zero, and applies reset during accumulation.

// File: rtl/phfe_pkg.sv
package phfe_pkg;

    typedef enum logic [1:0] {
        LD_HOLD    = 2'b00,
        LD_MOD     = 2'b01,
        LD_CAR     = 2'b10,
        LD_CLR_MOD = 2'b11
    } load_e;

    localparam int unsigned MODE_PM_BIT = 0;
    localparam int unsigned MODE_FM_BIT = 1;

endpackage

// File: rtl/phfe_capture.sv
module phfe_capture
    import phfe_pkg::*;
#(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_in,
    input  logic [1:0]    load_sel,
    input  logic [1:0]    mode_sel,
    output logic [PW-1:0] mod_q,
    output logic [PW-1:0] car_q,
    output logic [1:0]    mode_q
);

    typedef struct packed {
        logic [PW-1:0] mod_w;
        logic [PW-1:0] car_w;
        logic [1:0]    mode;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.mode = mode_sel;
        case (load_e'(load_sel))
            LD_MOD:     st_d.mod_w = phase_in;
            LD_CAR:     st_d.car_w = phase_in;
            LD_CLR_MOD: begin
                st_d.mod_w = '0;
                st_d.car_w = phase_in;
            end
            default:    st_d = st_q;
        endcase
        if (load_e'(load_sel) == LD_HOLD) begin
            st_d.mode = mode_sel;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mod_q  = st_q.mod_w;
    assign car_q  = st_q.car_w;
    assign mode_q = st_q.mode;

    // R2
    hold_both_chk: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'b00) |=> ($stable(mod_q) && $stable(car_q)));

    // R3
    clr_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'b11) |=> (mod_q == '0 && car_q == $past(phase_in)));

    // R1
    load_mod_chk: assert property (@(posedge clk) disable iff (rst)
        (load_sel == 2'b01) |=> (mod_q == $past(phase_in) && $stable(car_q)));

endmodule

// File: rtl/phfe_accum.sv
module phfe_accum
    import phfe_pkg::*;
#(
    parameter int unsigned PW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] mod_q,
    input  logic [PW-1:0] car_q,
    input  logic [1:0]    mode_q,
    output logic [PW-1:0] phase_out
);

    typedef struct packed {
        logic [PW-1:0] acc;
        logic [PW-1:0] outp;
    } acc_t;

    acc_t st_d, st_q;

    logic          fm_on, pm_on;
    logic [PW-1:0] step_w, post_w;

    always_comb begin
        fm_on  = mode_q[MODE_FM_BIT];
        pm_on  = mode_q[MODE_PM_BIT];
        step_w = car_q + (fm_on ? mod_q : '0);
        post_w = pm_on ? mod_q : '0;
        st_d   = st_q;
        if (!fm_on && !pm_on) begin
            st_d.acc  = '0;
            st_d.outp = car_q + mod_q;
        end else begin
            st_d.acc  = st_q.acc + step_w;
            st_d.outp = st_d.acc + post_w;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_out = st_q.outp;

    // R4
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b00) |=> (st_q.acc == '0));

    // R6
    pm_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == 2'b01) |=> (phase_out - st_q.acc == $past(mod_q)));

endmodule

// File: rtl/phfe_amp.sv
module phfe_amp #(
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] amp_in,
    input  logic          amp_en,
    output logic [AW-1:0] amp_out
);

    typedef struct packed {
        logic [AW-1:0] held;
        logic [AW-1:0] outp;
    } amp_t;

    amp_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.outp = st_q.held;
        if (amp_en) begin
            st_d.held = amp_in;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign amp_out = st_q.outp;

    // R9
    amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !amp_en |=> $stable(st_q.held));

    // R9
    amp_load_chk: assert property (@(posedge clk) disable iff (rst)
        amp_en |=> (st_q.held == $past(amp_in)));

endmodule

// File: rtl/phase_mod_front.sv
module phase_mod_front #(
    parameter int unsigned PW = 32,
    parameter int unsigned AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] phase_in,
    input  logic [1:0]    load_sel,
    input  logic [1:0]    mode_sel,
    input  logic [AW-1:0] amp_in,
    input  logic          amp_en,
    output logic [PW-1:0] phase_out,
    output logic [AW-1:0] amp_out
);

    logic [PW-1:0] mod_q, car_q;
    logic [1:0]    mode_q;

    phfe_capture #(.PW(PW)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .phase_in (phase_in),
        .load_sel (load_sel),
        .mode_sel (mode_sel),
        .mod_q    (mod_q),
        .car_q    (car_q),
        .mode_q   (mode_q)
    );

    phfe_accum #(.PW(PW)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .mod_q     (mod_q),
        .car_q     (car_q),
        .mode_q    (mode_q),
        .phase_out (phase_out)
    );

    phfe_amp #(.AW(AW)) u_amp (
        .clk     (clk),
        .rst     (rst),
        .amp_in  (amp_in),
        .amp_en  (amp_en),
        .amp_out (amp_out)
    );

    // R11
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (phase_out == '0 && amp_out == '0));

endmodule

// File: tb/sim_phase_mod_front.sv
module sim_phase_mod_front;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] phase_in = '0;
    logic [1:0]  load_sel = 2'b00;
    logic [1:0]  mode_sel = 2'b00;
    logic [14:0] amp_in = '0;
    logic        amp_en = 1'b0;
    logic [31:0] phase_out;
    logic [14:0] amp_out;

    int checks = 0;
    int errors = 0;

    // independent reference state, built from the requirements
    logic [31:0] m_mod = '0, m_car = '0, m_acc = '0, m_out = '0;
    logic [1:0]  m_mode = '0;
    logic [14:0] m_amp = '0, m_aout = '0;

    always #2 clk = ~clk;

    phase_mod_front u0 (
        .clk(clk), .rst(rst), .phase_in(phase_in), .load_sel(load_sel),
        .mode_sel(mode_sel), .amp_in(amp_in), .amp_en(amp_en),
        .phase_out(phase_out), .amp_out(amp_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [31:0] n_acc, n_out;
        @(posedge clk);
        #1;
        if (m_mode == 2'b00) begin
            n_acc = '0;
            n_out = m_car + m_mod;
        end else begin
            n_acc = m_acc + m_car + (m_mode[1] ? m_mod : 32'd0);
            n_out = n_acc + (m_mode[0] ? m_mod : 32'd0);
        end
        m_acc  = n_acc;
        m_out  = n_out;
        m_aout = m_amp;
        case (load_sel)
            2'b01: m_mod = phase_in;
            2'b10: m_car = phase_in;
            2'b11: begin m_mod = '0; m_car = phase_in; end
            default: ;
        endcase
        m_mode = mode_sel;
        if (amp_en) m_amp = amp_in;
        if (rst) begin
            m_mod = '0; m_car = '0; m_acc = '0; m_out = '0;
            m_mode = '0; m_amp = '0; m_aout = '0;
        end
        check({tag, " phase"}, phase_out, m_out);
        check({tag, " amp"}, {17'd0, amp_out}, {17'd0, m_aout});
    endtask

    task automatic set_in(input logic [1:0] ld, input logic [31:0] ph, input logic [1:0] md);
        load_sel = ld; phase_in = ph; mode_sel = md;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        step("R11 reset");
        step("R11 reset");
        check("R11 reset phase literal", phase_out, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_loads();
        set_in(2'b01, 32'h0000_0100, 2'b00); step("R1 load mod");
        set_in(2'b10, 32'h0000_1000, 2'b00); step("R1 load car");
        set_in(2'b00, 32'hDEAD_BEEF, 2'b00); step("R2 hold");
        step("R4 sum");
        check("R4 R10 literal sum", phase_out, 32'h0000_1100);
        set_in(2'b00, 32'h1234_5678, 2'b00); step("R2 hold again");
        check("R2 literal hold", phase_out, 32'h0000_1100);
        set_in(2'b11, 32'h0000_2000, 2'b00); step("R3 clear");
        set_in(2'b00, 32'h0, 2'b00); step("R3 clear out");
        check("R3 literal", phase_out, 32'h0000_2000);
    endtask

    task automatic t_fm();
        set_in(2'b01, 32'h5, 2'b00); step("R5 setup");
        set_in(2'b10, 32'h10, 2'b00); step("R5 setup");
        set_in(2'b00, 32'h0, 2'b10);
        for (int i = 0; i < 4; i++) step("R5 fm");
        check("R5 literal after 3", phase_out, 32'h3F);
        set_in(2'b00, 32'h0, 2'b00); step("R4 restart"); step("R4 restart");
        check("R4 literal idle", phase_out, 32'h15);
    endtask

    task automatic t_pm();
        set_in(2'b01, 32'h7, 2'b00); step("R6 setup");
        set_in(2'b10, 32'h100, 2'b00); step("R6 setup");
        set_in(2'b00, 32'h0, 2'b01);
        for (int i = 0; i < 4; i++) step("R6 pm");
        check("R6 literal after 3", phase_out, 32'h307);
    endtask

    task automatic t_both();
        set_in(2'b00, 32'h0, 2'b00); step("R7 idle");
        set_in(2'b01, 32'h3, 2'b00); step("R7 setup");
        set_in(2'b10, 32'h20, 2'b00); step("R7 setup");
        set_in(2'b00, 32'h0, 2'b11);
        for (int i = 0; i < 4; i++) step("R7 both");
        check("R7 literal after 3", phase_out, 32'h6C);
    endtask

    task automatic t_wrap();
        set_in(2'b00, 32'h0, 2'b00); step("R8 idle");
        set_in(2'b01, 32'h9000_0001, 2'b00); step("R8 setup");
        set_in(2'b10, 32'hC000_0000, 2'b00); step("R8 setup");
        step("R8 sum wrap");
        check("R8 literal idle sum", phase_out, 32'h5000_0001);
        set_in(2'b00, 32'h0, 2'b11);
        for (int i = 0; i < 6; i++) step("R8 wrap both");
        set_in(2'b00, 32'h0, 2'b10);
        for (int i = 0; i < 3; i++) step("R8 wrap fm");
    endtask

    task automatic t_amp();
        amp_in = 15'h1ABC; amp_en = 1'b1; step("R9 load");
        amp_in = 15'h7FFF; amp_en = 1'b0; step("R10 amp delay");
        check("R10 literal amp", {17'd0, amp_out}, 32'h1ABC);
        step("R9 hold");
        check("R9 literal hold", {17'd0, amp_out}, 32'h1ABC);
        amp_en = 1'b1; step("R9 load max"); amp_en = 1'b0; step("R9 out max");
        check("R9 literal max", {17'd0, amp_out}, 32'h7FFF);
    endtask

    task automatic t_mid_reset();
        set_in(2'b00, 32'h0, 2'b10);
        step("R11 run"); step("R11 run");
        rst = 1'b1; step("R11 mid reset");
        check("R11 literal phase", phase_out, 32'h0);
        check("R11 literal amp", {17'd0, amp_out}, 32'h0);
        rst = 1'b0; set_in(2'b00, 32'h0, 2'b00);
        step("R11 after"); step("R11 after");
    endtask

    initial begin
        t_reset();
        t_loads();
        t_fm();
        t_pm();
        t_both();
        t_wrap();
        t_amp();
        t_mid_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule